// File: doc/BRIEF.md
# YCbCr 4:2:2 Output Formatter

This block turns a stream of co-sited luma and chroma samples into a 4:2:2 video output with its own line and frame timing. A free-running timing generator divides each line into pixel periods. Each pixel period is two cycles of the core clock. Lines and frames have configurable totals. Inside the configured active window the block asks for one source pixel per pixel period. It pulses `pix_next_o` and captures `y_i`, `cb_i` and `cr_i` on that edge. Outside the window it drives the standard blanking codes.

There are two output formats, and `cfg_mode8` selects between them.
- In the wide format (`cfg_mode8`=0), `y_o` carries luma and `c_o` carries alternating Cb and Cr, once per pixel period.
- In the narrow format (`cfg_mode8`=1), all data goes on `y_o` as one byte per core clock, in the order chroma, luma, chroma, luma. This is twice the pixel rate.

Each chroma pair takes its Cb and its Cr from the even pixel of the pair. The start of active video on each line is delayed by twice `cfg_hstart` pixel periods. The block also produces an active-window flag `href_o`, sync strobes, and a pixel clock `pclk_o` that runs at half the core clock.

Top module: `yc422_out_fmt`

## Requirements
- R1: With the wide format, during active pixel k of a line (k counted from 0):
  - `y_o` shows Y(k) for both clocks of the pixel period.
  - `c_o` shows Cb(k) when k is even and Cr(k-1) when k is odd.
- R2: With the narrow format, `c_o` stays at 128 and `y_o` shows one byte per clock:
  - the chroma byte (Cb(k) for even k, Cr(k-1) for odd k) while `pclk_o` is 0;
  - then Y(k) while `pclk_o` is 1.
  - The byte order is therefore Cb0, Y0, Cr0, Y1, Cb2, Y2, and so on.
- R3: Outside the active window, `c_o` is 128 in both formats.
  - In the wide format, `y_o` is 16.
  - In the narrow format, `y_o` is 128 while `pclk_o` is 0 and 16 while `pclk_o` is 1.
- R4: Pixel periods of a line are numbered from 0.
  - `hs_n_o` is low for pixel periods 0 to HS_PULSE-1.
  - The first active pixel period is number 2*`cfg_hstart`. A value of 0 means active video starts with period 0.
- R5: `href_o` is high exactly during active pixel periods. Each active line has `cfg_width` such periods, which is 2*`cfg_width` consecutive clocks.
- R6: Chroma pairing restarts at Cb at the first active pixel of every line, including after a line with an odd width.
- R7: `cfg_mode8` is sampled only in the first clock of a frame (line 0, pixel period 0). A change at any other time takes effect from the next frame.
- R8: Line 0 of each frame is the vertical sync line: `vs_n_o` is low and there is no active output. Active lines are 1 to `cfg_lines`. No other line raises `href_o`.
- R9: Pixel capture and the pixel clock follow this timing:
  - `pix_next_o` is high during the first clock of each active pixel period, and the inputs are captured on the edge that ends that clock.
  - `pclk_o` is 0 in the first clock and 1 in the second clock of each pixel period, as seen on the registered outputs.
  - All outputs are registered and show the state one clock after the counters.
- R10: Reset is synchronous and active high. During reset:
  - `y_o` is 16 and `c_o` is 128;
  - `href_o`, `pclk_o` and `pix_next_o` are 0;
  - both sync outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode8 | input | 1 | 0: wide format (separate luma and chroma buses); 1: narrow format (interleaved bytes on `y_o`) |
| cfg_hstart | input | SW | Horizontal start delay in units of two pixel periods |
| cfg_width | input | HW | Active pixels per line |
| cfg_lines | input | VW | Active lines per frame |
| cfg_line_len | input | HW | Total pixel periods per line |
| cfg_frame_lines | input | VW | Total lines per frame |
| y_i | input | 8 | Source luma sample |
| cb_i | input | 8 | Source blue-difference sample |
| cr_i | input | 8 | Source red-difference sample |
| pix_next_o | output | 1 | The source pixel is taken at the next edge |
| y_o | output | 8 | Luma bus, or the interleaved byte bus in the narrow format |
| c_o | output | 8 | Chroma bus |
| href_o | output | 1 | Active window flag |
| hs_n_o | output | 1 | Horizontal sync, active low |
| vs_n_o | output | 1 | Vertical sync, active low |
| pclk_o | output | 1 | Pixel clock output |

## Verification
The assertions check the following on every clock:
- the wide-format blanking codes;
- that wide-format data holds through the second half of each pixel period;
- that `href_o` always starts in the chroma slot and runs in whole pixel periods;
- that each active run has exactly twice the configured width in clocks;
- that the sync line never carries active video.

Only the bench scenarios can show the actual byte order in each format. They also show that a mid-frame format change is deferred, that chroma pairing restarts after odd widths, and that the start offset matches the configured delay. The bench covers this by comparing every output against an independent model across frames with changing start delay, width and line count.

// File: rtl/yc422_pkg.sv
package yc422_pkg;

    // Flags passed from the timing generator to the data path.
    typedef struct packed {
        logic phase;   // 0: first clock of a pixel period, 1: second
        logic act;     // inside the active window
        logic hsync;   // horizontal sync interval
        logic vsync;   // vertical sync line
        logic mode8;   // effective output format
    } yc_tim_t;

    localparam logic [7:0] LUMA_BLANK   = 8'd16;
    localparam logic [7:0] CHROMA_BLANK = 8'd128;

endpackage

// File: rtl/yc422_timing.sv
module yc422_timing
    import yc422_pkg::*;
#(
    parameter int HW       = 11,
    parameter int VW       = 10,
    parameter int SW       = 8,
    parameter int HS_PULSE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_mode8,
    input  logic [SW-1:0] cfg_hstart,
    input  logic [HW-1:0] cfg_width,
    input  logic [VW-1:0] cfg_lines,
    input  logic [HW-1:0] cfg_line_len,
    input  logic [VW-1:0] cfg_frame_lines,
    output yc_tim_t       fl_o
);
    localparam int XW = HW + 2;

    typedef struct packed {
        logic          phase;
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          mode8;
    } tim_st_t;

    tim_st_t q, d;
    logic    frame_first;
    logic    mode_eff;
    logic [XW-1:0] act_lo, act_hi, h_x;

    always_comb begin
        frame_first = !q.phase && (q.h == '0) && (q.v == '0);
        mode_eff    = frame_first ? cfg_mode8 : q.mode8;

        d       = q;
        d.mode8 = mode_eff;
        d.phase = ~q.phase;
        if (q.phase) begin
            if (q.h >= cfg_line_len - 1'b1) begin
                d.h = '0;
                if (q.v >= cfg_frame_lines - 1'b1) d.v = '0;
                else                               d.v = q.v + 1'b1;
            end else begin
                d.h = q.h + 1'b1;
            end
        end

        act_lo = XW'({cfg_hstart, 1'b0});
        act_hi = act_lo + XW'(cfg_width);
        h_x    = XW'(q.h);

        fl_o.phase = q.phase;
        fl_o.act   = (h_x >= act_lo) && (h_x < act_hi)
                     && (q.v != '0) && (q.v <= cfg_lines);
        fl_o.hsync = q.h < HW'(HS_PULSE);
        fl_o.vsync = q.v == '0;
        fl_o.mode8 = mode_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R8
    vsync_noact_chk: assert property (@(posedge clk) disable iff (rst)
        fl_o.vsync |-> !fl_o.act);

endmodule

// File: rtl/yc422_datapath.sv
module yc422_datapath
    import yc422_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  yc_tim_t    fl_i,
    input  logic [7:0] y_i,
    input  logic [7:0] cb_i,
    input  logic [7:0] cr_i,
    output logic       pix_next_o,
    output logic [7:0] y_o,
    output logic [7:0] c_o,
    output logic       href_o,
    output logic       hs_n_o,
    output logic       vs_n_o,
    output logic       pclk_o
);
    typedef struct packed {
        logic [7:0] y;
        logic [7:0] c;
        logic       href;
        logic       hs_n;
        logic       vs_n;
        logic       pclk;
        logic       m8;
        logic       csel;     // 0: next chroma slot is Cb, 1: Cr
        logic [7:0] y_hold;
        logic [7:0] cr_hold;
    } dp_st_t;

    dp_st_t     q, d;
    logic [7:0] chroma;

    always_comb begin
        chroma = q.csel ? q.cr_hold : cb_i;

        d      = q;
        d.pclk = fl_i.phase;
        d.hs_n = ~fl_i.hsync;
        d.vs_n = ~fl_i.vsync;
        d.href = fl_i.act;
        d.m8   = fl_i.mode8;

        if (fl_i.act) begin
            if (!fl_i.phase) begin
                d.y_hold = y_i;
                d.csel   = ~q.csel;
                if (!q.csel) d.cr_hold = cr_i;
                if (fl_i.mode8) begin
                    d.y = chroma;
                    d.c = CHROMA_BLANK;
                end else begin
                    d.y = y_i;
                    d.c = chroma;
                end
            end else if (fl_i.mode8) begin
                d.y = q.y_hold;
                d.c = CHROMA_BLANK;
            end
        end else begin
            d.csel = 1'b0;
            d.c    = CHROMA_BLANK;
            d.y    = (fl_i.mode8 && !fl_i.phase) ? CHROMA_BLANK : LUMA_BLANK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{y: LUMA_BLANK, c: CHROMA_BLANK, href: 1'b0, hs_n: 1'b1,
                   vs_n: 1'b1, pclk: 1'b0, m8: 1'b0, csel: 1'b0,
                   y_hold: 8'd0, cr_hold: 8'd0};
        end else begin
            q <= d;
        end
    end

    assign pix_next_o = fl_i.act && !fl_i.phase;
    assign y_o    = q.y;
    assign c_o    = q.c;
    assign href_o = q.href;
    assign hs_n_o = q.hs_n;
    assign vs_n_o = q.vs_n;
    assign pclk_o = q.pclk;

    // R3
    blank16_chk: assert property (@(posedge clk) disable iff (rst)
        (!href_o && !q.m8) |-> (y_o == LUMA_BLANK && c_o == CHROMA_BLANK));

    // R1
    hold16_chk: assert property (@(posedge clk) disable iff (rst)
        (href_o && pclk_o && !q.m8) |-> ($stable(y_o) && $stable(c_o)));

    // R9
    href_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (href_o && !pclk_o) |=> href_o);

    // R5
    href_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(href_o) |-> !pclk_o);

endmodule

// File: rtl/yc422_out_fmt.sv
module yc422_out_fmt
    import yc422_pkg::*;
#(
    parameter int HW       = 11,
    parameter int VW       = 10,
    parameter int SW       = 8,
    parameter int HS_PULSE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_mode8,
    input  logic [SW-1:0] cfg_hstart,
    input  logic [HW-1:0] cfg_width,
    input  logic [VW-1:0] cfg_lines,
    input  logic [HW-1:0] cfg_line_len,
    input  logic [VW-1:0] cfg_frame_lines,
    input  logic [7:0]    y_i,
    input  logic [7:0]    cb_i,
    input  logic [7:0]    cr_i,
    output logic          pix_next_o,
    output logic [7:0]    y_o,
    output logic [7:0]    c_o,
    output logic          href_o,
    output logic          hs_n_o,
    output logic          vs_n_o,
    output logic          pclk_o
);
    yc_tim_t fl;

    yc422_timing #(
        .HW(HW), .VW(VW), .SW(SW), .HS_PULSE(HS_PULSE)
    ) u_timing (
        .clk(clk), .rst(rst), .cfg_mode8(cfg_mode8), .cfg_hstart(cfg_hstart),
        .cfg_width(cfg_width), .cfg_lines(cfg_lines),
        .cfg_line_len(cfg_line_len), .cfg_frame_lines(cfg_frame_lines),
        .fl_o(fl)
    );

    yc422_datapath u_dp (
        .clk(clk), .rst(rst), .fl_i(fl), .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i),
        .pix_next_o(pix_next_o), .y_o(y_o), .c_o(c_o), .href_o(href_o),
        .hs_n_o(hs_n_o), .vs_n_o(vs_n_o), .pclk_o(pclk_o)
    );

    // Run-length checker for the active flag.
    logic [HW:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (href_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R5
    href_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(href_o) |-> (run_q == {cfg_width, 1'b0}));

endmodule

// File: tb/sim_yc422_out_fmt.sv
module sim_yc422_out_fmt;
    localparam int L  = 40;   // pixel periods per line
    localparam int F  = 8;    // lines per frame
    localparam int HP = 8;    // sync pulse length
    localparam int NCYC = 6 * F * L * 2 + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_mode8 = 1'b0;
    logic [7:0]  cfg_hstart = 8'd3;
    logic [10:0] cfg_width = 11'd16;
    logic [9:0]  cfg_lines = 10'd5;
    logic [10:0] cfg_line_len = 11'(L);
    logic [9:0]  cfg_frame_lines = 10'(F);
    logic [7:0]  y_i = 8'd0, cb_i = 8'd0, cr_i = 8'd0;
    logic        pix_next_o, href_o, hs_n_o, vs_n_o, pclk_o;
    logic [7:0]  y_o, c_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    yc422_out_fmt #(.HS_PULSE(HP)) u0 (
        .clk(clk), .rst(rst), .cfg_mode8(cfg_mode8), .cfg_hstart(cfg_hstart),
        .cfg_width(cfg_width), .cfg_lines(cfg_lines),
        .cfg_line_len(cfg_line_len), .cfg_frame_lines(cfg_frame_lines),
        .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .pix_next_o(pix_next_o),
        .y_o(y_o), .c_o(c_o), .href_o(href_o), .hs_n_o(hs_n_o),
        .vs_n_o(vs_n_o), .pclk_o(pclk_o)
    );

    function automatic int fy(int v, int k);  return (v * 37 + k * 5 + 1) & 255;   endfunction
    function automatic int fcb(int v, int k); return (v * 11 + k * 9 + 64) & 255;  endfunction
    function automatic int fcr(int v, int k); return (v * 3 + k * 13 + 200) & 255; endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model state
    int ph = 0, h = 0, v = 0, fr = 0, m = 0;
    int e_y, e_c, e_href, e_hs, e_vs, e_pclk;
    string ty, tc, th;

    initial begin
        bit have = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 y_o", y_o, 16);
        check("R10 c_o", c_o, 128);
        check("R10 href_o", href_o, 0);
        check("R10 hs_n_o", hs_n_o, 1);
        check("R10 vs_n_o", vs_n_o, 1);
        check("R10 pclk_o", pclk_o, 0);
        check("R10 pix_next_o", pix_next_o, 0);
        rst = 1'b0;
        for (int i = 0; i < NCYC; i++) begin
            int hs, w, ln, k, chroma, a;
            if (have) begin
                check(ty, y_o, e_y);
                check(tc, c_o, e_c);
                check(th, href_o, e_href);
                check("R4 hs_n_o", hs_n_o, e_hs);
                check("R8 vs_n_o", vs_n_o, e_vs);
                check("R9 pclk_o", pclk_o, e_pclk);
            end
            // scenario: format change mid-frame, geometry at line 0
            if (v == 3 && h == 0 && ph == 0)
                cfg_mode8 = (fr == 0 || fr == 2) ? 1'b1 : 1'b0;
            if (v == 0 && h == 2 && ph == 0) begin
                case (fr)
                    2, 3: begin cfg_hstart = 8'd0;  cfg_width = 11'd7;  cfg_lines = 10'd5; end
                    4:    begin cfg_hstart = 8'd12; cfg_width = 11'd15; cfg_lines = 10'd7; end
                    5:    begin cfg_hstart = 8'd5;  cfg_width = 11'd1;  cfg_lines = 10'd1; end
                    default: ;
                endcase
            end
            if (h == 0 && v == 0 && ph == 0) m = cfg_mode8;
            hs = int'(cfg_hstart); w = int'(cfg_width); ln = int'(cfg_lines);
            a = (v >= 1 && v <= ln && h >= 2 * hs && h < 2 * hs + w) ? 1 : 0;
            k = h - 2 * hs;
            chroma = (k % 2 == 0) ? fcb(v, k) : fcr(v, k - 1);
            if (a == 1) begin
                y_i = 8'(fy(v, k)); cb_i = 8'(fcb(v, k)); cr_i = 8'(fcr(v, k));
            end else begin
                y_i = 8'hEE; cb_i = 8'hE1; cr_i = 8'hE2;
            end
            #1;
            check("R9 pix_next_o", pix_next_o, (a == 1 && ph == 0) ? 1 : 0);
            if (m == 0) begin
                e_y = a ? fy(v, k) : 16;
                e_c = a ? chroma : 128;
                ty = !a ? "R3 y_o blank" : (m != int'(cfg_mode8) ? "R7 y_o" : "R1 y_o");
                tc = !a ? "R3 c_o blank" : (k < 2 ? "R6 c_o" : "R1 c_o");
            end else begin
                e_c = 128;
                e_y = a ? (ph == 0 ? chroma : fy(v, k)) : (ph == 0 ? 128 : 16);
                ty = !a ? "R3 y_o blank8" : (m != int'(cfg_mode8) ? "R7 y_o" :
                     ((k < 2 && ph == 0) ? "R6 y_o" : "R2 y_o"));
                tc = !a ? "R3 c_o blank8" : "R2 c_o";
            end
            e_href = a;
            th = (v == 0 || v > ln) ? "R8 href_o" : (h == 2 * hs ? "R4 href_o" : "R5 href_o");
            e_hs = (h < HP) ? 0 : 1;
            e_vs = (v == 0) ? 0 : 1;
            e_pclk = ph;
            have = 1;
            if (ph == 1) begin
                if (h == L - 1) begin
                    h = 0;
                    if (v == F - 1) begin v = 0; fr++; end
                    else v++;
                end else h++;
            end
            ph ^= 1;
            @(negedge clk);
        end
        check(ty, y_o, e_y);
        check(tc, c_o, e_c);
        check(th, href_o, e_href);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule